// File: doc/BRIEF.md
# Processor Clock Throttle Arbiter

This block decides which processor power condition is in force and drives the stop-clock output to match. It weighs a sleep request, a deep-idle (C2) request, a thermal override and a software throttle setting under a fixed ranking. Sleep outranks C2. C2 outranks both throttle sources. Throttling is the lowest. While throttling, stop-clock is asserted for part of every period of 1024 bus clocks. The asserted portion always begins at the start of a period, which is set by a free-running counter.

The controller has eight states. Running/C1 (`ST_RUN`) keeps the processor clocked. Three throttle states share the period: `ST_THR_OFF` waits with stop-clock low for the counter to wrap. `ST_THR_ON` holds stop-clock high for the duty window. `ST_THR_GRANT` is the same window after the processor has acknowledged with a stop-grant, and it is reported as C2. Deep idle (`ST_C2`) holds stop-clock high until a break event. Three sleep states also hold stop-clock high: `ST_SLP_WAIT` waits for the stop-grant, `ST_SLP_PULSE` raises the one-clock sleep-entry request, and `ST_SLP` holds.

The transitions are as follows:
- A sleep request moves any state except the sleep states to `ST_SLP_WAIT`.
- A C2 request moves running or throttle states to `ST_C2`.
- A break event moves `ST_C2` to `ST_THR_OFF` if throttling is wanted, and otherwise to `ST_RUN`.
- `ST_THR_OFF` goes to `ST_THR_ON` at the counter wrap.
- `ST_THR_ON` goes to `ST_THR_GRANT` on an acknowledge.
- Both on-states go back to `ST_THR_OFF` when the window ends.
- A throttle state goes to `ST_RUN` when throttling stops.
- `ST_SLP_WAIT` goes to `ST_SLP_PULSE` on an acknowledge, and `ST_SLP_PULSE` then goes to `ST_SLP`.
- Any sleep state goes to `ST_RUN` when the sleep request drops.

Top module: `clk_throttle_arbiter`

## Requirements
- R1: While `sleep_en` is 1, the state indicator `pstate` reads 3 (sleep) and `stpclk` is 1 from the next clock on. This holds whatever the throttle, thermal or C2 inputs do.
- R2: In sleep, `sleep_req` is 1 for exactly one clock. That clock is the one after `stop_grant_ack` is seen with `stpclk` asserted. `sleep_req` stays 0 before the acknowledge.
- R3: When `sleep_en` drops in sleep, `pstate` reads 0 (running/C1) on the next clock.
- R4: A `c2_req` with `sleep_en` low, from running or throttling, gives `pstate` = 1 (C2) with `stpclk` = 1 on the next clock. That state holds until `brk_evt`. `stpclk` is 1 whenever `pstate` is 1 or 3.
- R5: A `brk_evt` in C2 gives `stpclk` = 0 on the next clock. `pstate` then reads 2 (throttling) if a throttle source is active, and 0 otherwise.
- R6: The period counter counts 1024 clocks, runs freely, and is cleared by reset. A throttle assertion of `stpclk` starts only on the clock after the counter was 0, so after C2 exit the first assertion can wait up to a full period.
- R7: Software throttling with `sw_thr_en` = 1 holds `stpclk` high for `sw_duty`×128 clocks of each period. A `sw_duty` of 0, or `sw_thr_en` = 0, gives no throttling.
- R8: `therm_ovr` = 1 throttles at a duty of 4 (512 clocks) even when `sw_thr_en` is 0. When both sources are active, the larger duty applies.
- R9: A `stop_grant_ack` while a throttle window holds `stpclk` high makes `pstate` read 1 on the next clock. It returns to 2 when the window ends and `stpclk` drops.
- R10: After reset, `pstate` is 0, `stpclk` is 0 and `sleep_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_thr_en | input | 1 | Software throttle enable |
| sw_duty | input | 3 | Software duty setting, in eighths of a period |
| therm_ovr | input | 1 | Thermal override, forces throttling |
| c2_req | input | 1 | Deep-idle (C2) entry request |
| brk_evt | input | 1 | Break event, ends C2 |
| sleep_en | input | 1 | Sleep entry request |
| stop_grant_ack | input | 1 | Processor stop-grant acknowledge |
| stpclk | output | 1 | Stop-clock, 1 = processor clock stopped |
| sleep_req | output | 1 | One-clock sleep-entry request |
| pstate | output | 2 | 0 running/C1, 1 C2, 2 throttling, 3 sleep |

## Verification
All outputs are decoded from the state register, so any input change shows up one clock later. The bench drives inputs just after a falling edge and samples one falling edge after the rising edge that takes them. Throttle edges follow the period counter. A rise is due on the sample where the bench's own reset-cleared clock count reads 1 (modulo 1024), and a fall where it reads duty×128+1. The checks compare against those counts. During the random phase, a cycle-level reference model built from the requirements is stepped on the same rising edge and compared at every falling edge.

// File: rtl/clk_thr_pkg.sv
package clk_thr_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_THR_OFF,
        ST_THR_ON,
        ST_THR_GRANT,
        ST_C2,
        ST_SLP_WAIT,
        ST_SLP_PULSE,
        ST_SLP
    } arb_state_t;

    localparam logic [1:0] PS_RUN   = 2'd0;
    localparam logic [1:0] PS_C2    = 2'd1;
    localparam logic [1:0] PS_THROT = 2'd2;
    localparam logic [1:0] PS_SLEEP = 2'd3;

endpackage

// File: rtl/thr_period_counter.sv
module thr_period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             at_boundary
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_boundary = (cnt == '0);

endmodule

// File: rtl/thr_duty_select.sv
module thr_duty_select #(
    parameter int CNT_W      = 10,
    parameter int DUTY_W     = 3,
    parameter int THERM_DUTY = 4
) (
    input  logic              sw_thr_en,
    input  logic [DUTY_W-1:0] sw_duty,
    input  logic              therm_ovr,
    output logic              thr_active,
    output logic [CNT_W-1:0]  on_len
);

    localparam int STEP_SH = CNT_W - DUTY_W;
    localparam logic [DUTY_W-1:0] THERM_D = DUTY_W'(THERM_DUTY);

    logic [DUTY_W-1:0] sw_eff;
    logic [DUTY_W-1:0] th_eff;
    logic [DUTY_W-1:0] duty_eff;

    always_comb begin
        sw_eff     = sw_thr_en ? sw_duty : '0;
        th_eff     = therm_ovr ? THERM_D : '0;
        duty_eff   = (sw_eff > th_eff) ? sw_eff : th_eff;
        thr_active = (duty_eff != '0);
        on_len     = CNT_W'(duty_eff) << STEP_SH;
    end

endmodule

// File: rtl/thr_arb_fsm.sv
module thr_arb_fsm
    import clk_thr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic             c2_req,
    input  logic             brk_evt,
    input  logic             stop_grant_ack,
    input  logic             thr_active,
    input  logic             at_boundary,
    input  logic [CNT_W-1:0] period_cnt,
    input  logic [CNT_W-1:0] on_len,
    output arb_state_t       cur_state,
    output logic             stpclk,
    output logic             sleep_req,
    output logic [1:0]       pstate
);

    arb_state_t nxt_state;
    logic       window_done;

    assign window_done = (period_cnt >= on_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_state <= ST_RUN;
        end else begin
            cur_state <= nxt_state;
        end
    end

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_RUN: begin
                if (sleep_en)        nxt_state = ST_SLP_WAIT;
                else if (c2_req)     nxt_state = ST_C2;
                else if (thr_active) nxt_state = ST_THR_OFF;
            end
            ST_THR_OFF: begin
                if (sleep_en)         nxt_state = ST_SLP_WAIT;
                else if (c2_req)      nxt_state = ST_C2;
                else if (!thr_active) nxt_state = ST_RUN;
                else if (at_boundary) nxt_state = ST_THR_ON;
            end
            ST_THR_ON: begin
                if (sleep_en)            nxt_state = ST_SLP_WAIT;
                else if (c2_req)         nxt_state = ST_C2;
                else if (!thr_active)    nxt_state = ST_RUN;
                else if (window_done)    nxt_state = ST_THR_OFF;
                else if (stop_grant_ack) nxt_state = ST_THR_GRANT;
            end
            ST_THR_GRANT: begin
                if (sleep_en)         nxt_state = ST_SLP_WAIT;
                else if (c2_req)      nxt_state = ST_C2;
                else if (!thr_active) nxt_state = ST_RUN;
                else if (window_done) nxt_state = ST_THR_OFF;
            end
            ST_C2: begin
                if (sleep_en)     nxt_state = ST_SLP_WAIT;
                else if (brk_evt) nxt_state = thr_active ? ST_THR_OFF : ST_RUN;
            end
            ST_SLP_WAIT: begin
                if (!sleep_en)           nxt_state = ST_RUN;
                else if (stop_grant_ack) nxt_state = ST_SLP_PULSE;
            end
            ST_SLP_PULSE: begin
                nxt_state = sleep_en ? ST_SLP : ST_RUN;
            end
            ST_SLP: begin
                if (!sleep_en) nxt_state = ST_RUN;
            end
            default: nxt_state = ST_RUN;
        endcase
    end

    always_comb begin
        stpclk    = 1'b0;
        sleep_req = 1'b0;
        pstate    = PS_RUN;
        unique case (cur_state)
            ST_RUN: begin
                pstate = PS_RUN;
            end
            ST_THR_OFF: begin
                pstate = PS_THROT;
            end
            ST_THR_ON: begin
                stpclk = 1'b1;
                pstate = PS_THROT;
            end
            ST_THR_GRANT: begin
                stpclk = 1'b1;
                pstate = PS_C2;
            end
            ST_C2: begin
                stpclk = 1'b1;
                pstate = PS_C2;
            end
            ST_SLP_WAIT: begin
                stpclk = 1'b1;
                pstate = PS_SLEEP;
            end
            ST_SLP_PULSE: begin
                stpclk    = 1'b1;
                sleep_req = 1'b1;
                pstate    = PS_SLEEP;
            end
            ST_SLP: begin
                stpclk = 1'b1;
                pstate = PS_SLEEP;
            end
            default: begin
                pstate = PS_RUN;
            end
        endcase
    end

endmodule

// File: rtl/clk_throttle_arbiter.sv
module clk_throttle_arbiter
    import clk_thr_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int DUTY_W     = 3,
    parameter int THERM_DUTY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_thr_en,
    input  logic [DUTY_W-1:0] sw_duty,
    input  logic              therm_ovr,
    input  logic              c2_req,
    input  logic              brk_evt,
    input  logic              sleep_en,
    input  logic              stop_grant_ack,
    output logic              stpclk,
    output logic              sleep_req,
    output logic [1:0]        pstate
);

    logic [CNT_W-1:0] period_cnt;
    logic             at_boundary;
    logic             thr_active;
    logic [CNT_W-1:0] on_len;
    arb_state_t       cur_state;

    thr_period_counter #(
        .CNT_W(CNT_W)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (period_cnt),
        .at_boundary(at_boundary)
    );

    thr_duty_select #(
        .CNT_W     (CNT_W),
        .DUTY_W    (DUTY_W),
        .THERM_DUTY(THERM_DUTY)
    ) u_duty (
        .sw_thr_en (sw_thr_en),
        .sw_duty   (sw_duty),
        .therm_ovr (therm_ovr),
        .thr_active(thr_active),
        .on_len    (on_len)
    );

    thr_arb_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_en      (sleep_en),
        .c2_req        (c2_req),
        .brk_evt       (brk_evt),
        .stop_grant_ack(stop_grant_ack),
        .thr_active    (thr_active),
        .at_boundary   (at_boundary),
        .period_cnt    (period_cnt),
        .on_len        (on_len),
        .cur_state     (cur_state),
        .stpclk        (stpclk),
        .sleep_req     (sleep_req),
        .pstate        (pstate)
    );

endmodule

// File: rtl/clk_throttle_arbiter_chk.sv
module clk_throttle_arbiter_chk
    import clk_thr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             therm_ovr,
    input logic             c2_req,
    input logic             brk_evt,
    input logic             sleep_en,
    input logic             stop_grant_ack,
    input logic             stpclk,
    input logic             sleep_req,
    input logic [1:0]       pstate,
    input logic [CNT_W-1:0] period_cnt,
    input arb_state_t       cur_state
);

    assert_sleep_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_en |=> (pstate == PS_SLEEP && stpclk));

    assert_sleep_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !sleep_req);

    assert_sleep_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (stpclk && $past(stop_grant_ack)));

    assert_sleep_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_SLEEP && !sleep_en) |=> pstate == PS_RUN);

    assert_c2_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_en && c2_req && !brk_evt && pstate != PS_SLEEP) |=> (pstate == PS_C2 && stpclk));

    assert_c2_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_C2 && !brk_evt && !sleep_en) |=> cur_state == ST_C2);

    assert_stpclk_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_C2 || pstate == PS_SLEEP) |-> stpclk);

    assert_break_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_C2 && brk_evt && !sleep_en) |=> (!stpclk && pstate != PS_C2));

    assert_rise_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stpclk) && pstate == PS_THROT) |-> ($past(period_cnt) == '0));

    assert_therm_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_RUN && therm_ovr && !sleep_en && !c2_req) |=> pstate == PS_THROT);

    assert_grant_shows_c2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_THROT && stpclk && stop_grant_ack && !sleep_en && !c2_req)
            |=> (pstate == PS_C2 || !stpclk));

endmodule

bind clk_throttle_arbiter clk_throttle_arbiter_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .therm_ovr     (therm_ovr),
    .c2_req        (c2_req),
    .brk_evt       (brk_evt),
    .sleep_en      (sleep_en),
    .stop_grant_ack(stop_grant_ack),
    .stpclk        (stpclk),
    .sleep_req     (sleep_req),
    .pstate        (pstate),
    .period_cnt    (period_cnt),
    .cur_state     (cur_state)
);

// File: tb/test_clk_throttle_arbiter.sv
`timescale 1ns/1ps
module test_clk_throttle_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 1024;
    localparam int STEP       = 128;
    localparam int THERM_D    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_thr_en = 1'b0;
    logic [2:0] sw_duty = 3'd0;
    logic       therm_ovr = 1'b0;
    logic       c2_req = 1'b0;
    logic       brk_evt = 1'b0;
    logic       sleep_en = 1'b0;
    logic       stop_grant_ack = 1'b0;
    logic       stpclk;
    logic       sleep_req;
    logic [1:0] pstate;

    int n_chk = 0;
    int n_err = 0;
    int bcnt  = 0;
    int m_st  = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_throttle_arbiter i_clk_throttle_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_thr_en     (sw_thr_en),
        .sw_duty       (sw_duty),
        .therm_ovr     (therm_ovr),
        .c2_req        (c2_req),
        .brk_evt       (brk_evt),
        .sleep_en      (sleep_en),
        .stop_grant_ack(stop_grant_ack),
        .stpclk        (stpclk),
        .sleep_req     (sleep_req),
        .pstate        (pstate)
    );

    // bench copy of the period count (R6): cleared by reset, wraps at PERIOD
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= (bcnt + 1) % PERIOD;
    end

    function automatic int exp_on(input bit en, input int duty, input bit th);
        int a;
        int b;
        a = en ? duty : 0;
        b = th ? THERM_D : 0;
        return ((a > b) ? a : b) * STEP;
    endfunction

    // reference model states: 0 run,1 wait,2 on,3 on-granted,4 c2,5 slp-wait,6 slp-pulse,7 slp
    function automatic int model_next(input int st, input int cnt);
        int ol;
        bit act;
        ol  = exp_on(sw_thr_en, int'(sw_duty), therm_ovr);
        act = (ol != 0);
        case (st)
            0: return sleep_en ? 5 : c2_req ? 4 : act ? 1 : 0;
            1: return sleep_en ? 5 : c2_req ? 4 : !act ? 0 : (cnt == 0) ? 2 : 1;
            2: return sleep_en ? 5 : c2_req ? 4 : !act ? 0 : (cnt >= ol) ? 1 : stop_grant_ack ? 3 : 2;
            3: return sleep_en ? 5 : c2_req ? 4 : !act ? 0 : (cnt >= ol) ? 1 : 3;
            4: return sleep_en ? 5 : brk_evt ? (act ? 1 : 0) : 4;
            5: return !sleep_en ? 0 : stop_grant_ack ? 6 : 5;
            6: return sleep_en ? 7 : 0;
            default: return sleep_en ? 7 : 0;
        endcase
    endfunction

    function automatic int m_ps(input int st);
        case (st)
            0: return 0;
            1, 2: return 2;
            3, 4: return 1;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_st <= 0;
        else        m_st <= model_next(m_st, bcnt);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(output int waited);
        bit prev;
        waited = 0;
        prev = stpclk;
        while (waited < 3000) begin
            @(negedge clk);
            waited++;
            if (stpclk && !prev) break;
            prev = stpclk;
        end
    endtask

    task automatic measure(output int hi);
        hi = 0;
        repeat (PERIOD) begin
            @(negedge clk);
            if (stpclk) hi++;
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R7 random stpclk", int'(stpclk), (m_st >= 2 && m_st != 1) ? 1 : 0);
            chk("R4 random pstate", int'(pstate), m_ps(m_st));
            chk("R2 random sleep_req", int'(sleep_req), (m_st == 6) ? 1 : 0);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int w;
        int hi;
        int bad;
        void'($urandom(32'h5eed_0042));
        cyc(4);
        // R10 reset state
        chk("R10 stpclk", int'(stpclk), 0);
        chk("R10 pstate", int'(pstate), 0);
        chk("R10 sleep_req", int'(sleep_req), 0);
        rst_n = 1'b1;

        // R7 software throttle disabled with nonzero duty
        sw_duty = 3'd5;
        cyc(2);
        measure(hi);
        chk("R7 disabled high count", hi, 0);
        chk("R7 disabled pstate", int'(pstate), 0);

        // R7 duty zero while enabled
        sw_thr_en = 1'b1; sw_duty = 3'd0;
        cyc(2);
        measure(hi);
        chk("R7 duty0 high count", hi, 0);

        // R7 duty 2, R6 rise aligned
        sw_duty = 3'd2;
        wait_rise(w);
        chk("R6 rise at boundary", bcnt, 1);
        chk("R7 throttle pstate", int'(pstate), 2);
        cyc(1);
        measure(hi);
        chk("R7 duty2 high count", hi, 2 * STEP);

        // R9 stop-grant during on window
        wait_rise(w);
        cyc(3);
        stop_grant_ack = 1'b1; cyc(1); stop_grant_ack = 1'b0;
        chk("R9 grant pstate", int'(pstate), 1);
        chk("R9 grant stpclk", int'(stpclk), 1);
        while (stpclk) cyc(1);
        chk("R9 back to throttle", int'(pstate), 2);
        chk("R7 fall position", bcnt, 2 * STEP + 1);

        // R8 thermal alone, then combined
        sw_thr_en = 1'b0; therm_ovr = 1'b1;
        wait_rise(w);
        cyc(1);
        measure(hi);
        chk("R8 thermal high count", hi, THERM_D * STEP);
        sw_thr_en = 1'b1; sw_duty = 3'd6;
        wait_rise(w);
        cyc(1);
        measure(hi);
        chk("R8 larger duty count", hi, 6 * STEP);

        // R4 C2 during throttle, R5 exit, R6 delayed re-assert
        cyc(37);
        c2_req = 1'b1; cyc(1); c2_req = 1'b0;
        chk("R4 c2 pstate", int'(pstate), 1);
        chk("R4 c2 stpclk", int'(stpclk), 1);
        bad = 0;
        repeat (1200) begin cyc(1); if (pstate != 2'd1 || !stpclk) bad++; end
        chk("R4 c2 held cycles bad", bad, 0);
        brk_evt = 1'b1; cyc(1); brk_evt = 1'b0;
        chk("R5 exit pstate", int'(pstate), 2);
        chk("R5 exit stpclk", int'(stpclk), 0);
        wait_rise(w);
        chk("R6 post-c2 rise at boundary", bcnt, 1);

        // R5 C2 from run without throttle
        therm_ovr = 1'b0; sw_thr_en = 1'b0;
        cyc(2);
        chk("R5 idle before c2", int'(pstate), 0);
        c2_req = 1'b1; cyc(1); c2_req = 1'b0;
        chk("R4 c2 from run", int'(pstate), 1);
        brk_evt = 1'b1; cyc(1); brk_evt = 1'b0;
        chk("R5 exit to run", int'(pstate), 0);

        // R1 sleep over thermal and software throttle
        therm_ovr = 1'b1; sw_thr_en = 1'b1; sw_duty = 3'd3;
        wait_rise(w);
        cyc(5);
        sleep_en = 1'b1; cyc(1);
        chk("R1 sleep pstate", int'(pstate), 3);
        chk("R1 sleep stpclk", int'(stpclk), 1);
        bad = 0;
        repeat (1100) begin
            cyc(1);
            if (pstate != 2'd3 || !stpclk) bad++;
            if (sleep_req) bad++;
        end
        chk("R1 sleep held, R2 no early req", bad, 0);
        stop_grant_ack = 1'b1; cyc(1); stop_grant_ack = 1'b0;
        chk("R2 sleep_req pulse", int'(sleep_req), 1);
        cyc(1);
        chk("R2 sleep_req single", int'(sleep_req), 0);
        chk("R1 still sleep", int'(pstate), 3);
        therm_ovr = 1'b0; sw_thr_en = 1'b0;
        sleep_en = 1'b0; cyc(1);
        chk("R3 sleep exit", int'(pstate), 0);

        // R1 sleep and C2 requested together
        sleep_en = 1'b1; c2_req = 1'b1; cyc(1); c2_req = 1'b0;
        chk("R1 sleep beats c2", int'(pstate), 3);
        sleep_en = 1'b0; cyc(1);
        chk("R3 exit again", int'(pstate), 0);

        // random phase against reference model
        rst_n = 1'b0; cyc(3); rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (6000) begin
            if ($urandom % 200 == 0) sleep_en  = ~sleep_en;
            if ($urandom % 300 == 0) therm_ovr = ~therm_ovr;
            if ($urandom % 300 == 0) sw_thr_en = ~sw_thr_en;
            if ($urandom % 400 == 0) sw_duty   = 3'($urandom);
            c2_req         = ($urandom % 40 == 0);
            brk_evt        = ($urandom % 25 == 0);
            stop_grant_ack = ($urandom % 6 == 0);
            cyc(1);
        end
        cmp_en = 1'b0;

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule